// File: doc/BRIEF.md
# Class-Partitioned Integer ALU

A purely combinational integer arithmetic-logic unit for a load/store processor datapath. Two operands, a shift distance and a four-bit operation code go in. A result word, a signed-overflow flag and a zero flag come out in the same cycle.

The operation code has two fields. The upper two bits pick one of four operation classes: bitwise logic, add/subtract, set-on-less-than, or shift. The lower two bits pick the operation within that class. All four class units evaluate in parallel, and a four-way selector keeps one result.

The less-than classes use no comparator of their own. They reuse the adder, whose subtract codes match the comparison codes. The decision comes from the difference's sign, the carry out, and the sign bits of the operands.

Top module: `alu_classsel`

## Requirements
- R1: With opcode[3:2]=00 the result is the bitwise logic of the operands: opcode[1:0] 00 gives AND, 01 OR, 10 XOR, 11 NOR.
- R2: With opcode[3:2]=01 the result is the sum modulo 2^W: opcode[1:0] 00 signed add, 01 unsigned add, 10 signed subtract (A-B), 11 unsigned subtract.
- R3: `ovf` is 1 only for opcodes 0100 and 0110, and only when the operand signs agree (B taken inverted for 0110) while the result sign differs. It is 0 for every other opcode.
- R4: `zero` is 1 exactly when the adder output is all zeros, in every class. The adder adds when opcode[1]=0 and computes A-B when opcode[1]=1.
- R5: Opcode 1010 (signed less-than) gives 1 in bit 0 when A<B as two's complement. If the operand signs differ, the negative operand is the smaller. If they agree, the sign of A-B decides.
- R6: Opcode 1011 (unsigned less-than) gives 1 in bit 0 when A<B unsigned, that is when A+~B+1 produces no carry out. Opcodes 1000 and 1001 give 0. Bits [W-1:1] are 0 for every comparison opcode.
- R7: With opcode[3:2]=11: opcode[1:0] 00 shifts A left with zero fill, 10 shifts right with zero fill, 11 shifts right with copies of A's sign bit, and 01 passes A unchanged.
- R8: The shift distance is `shamt` (0 to W-1). A distance of 0 returns A for every shift opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W (32) | first operand |
| opb | input | W (32) | second operand |
| shamt | input | SHW (5) | shift distance |
| opcode | input | 4 | class field [3:2], operation field [1:0] |
| result | output | W (32) | selected class result |
| ovf | output | 1 | signed add/subtract overflow |
| zero | output | 1 | adder output is all zeros |

## Verification
The bound checker tests a set of properties on every input change:
- AND under the logic code
- overflow appearing only under the two signed arithmetic opcodes
- upper comparison bits staying clear
- zero matching an all-zero arithmetic result
- the identity shift at distance zero

The exact sums, the overflow boundary at the signed extremes, the signed-versus-unsigned less-than split, the fill behaviour of each right shift and the full sweep of shift distances are only shown by the bench's vectors.

// File: rtl/alu_classsel.sv
module alu_classsel #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic [SHW-1:0] shamt,
  input  logic [3:0]     opcode,
  output logic [W-1:0]   result,
  output logic           ovf,
  output logic           zero
);
  localparam int MSB = W - 1;

  logic [1:0]   cls, fn;
  logic [W-1:0] logic_r, arith_r, cmp_r, shift_r;
  logic [W-1:0] b_eff;
  logic         do_sub, carry, less;

  assign cls = opcode[3:2];
  assign fn  = opcode[1:0];

  always_comb begin
    case (fn)
      2'b00:   logic_r = opa & opb;
      2'b01:   logic_r = opa | opb;
      2'b10:   logic_r = opa ^ opb;
      default: logic_r = ~(opa | opb);
    endcase
  end

  assign do_sub           = fn[1];
  assign b_eff            = do_sub ? ~opb : opb;
  assign {carry, arith_r} = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};

  assign ovf  = (cls == 2'b01) && !fn[0] &&
                (opa[MSB] == b_eff[MSB]) && (arith_r[MSB] != opa[MSB]);
  assign zero = (arith_r == '0);

  always_comb begin
    if (fn[0])
      less = !carry;
    else if (opa[MSB] != opb[MSB])
      less = opa[MSB];
    else
      less = arith_r[MSB];
  end
  assign cmp_r = {{(W-1){1'b0}}, fn[1] & less};

  always_comb begin
    case (fn)
      2'b00:   shift_r = opa << shamt;
      2'b10:   shift_r = opa >> shamt;
      2'b11:   shift_r = W'($signed(opa) >>> shamt);
      default: shift_r = opa;
    endcase
  end

  always_comb begin
    case (cls)
      2'b00:   result = logic_r;
      2'b01:   result = arith_r;
      2'b10:   result = cmp_r;
      default: result = shift_r;
    endcase
  end
endmodule

module alu_classsel_checker #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input logic [W-1:0]   opa,
  input logic [W-1:0]   opb,
  input logic [SHW-1:0] shamt,
  input logic [3:0]     opcode,
  input logic [W-1:0]   result,
  input logic           ovf,
  input logic           zero
);
  always_comb begin
    if (opcode == 4'b0000)
      assert_and_value_R1: assert (result == (opa & opb));
    if (ovf)
      assert_ovf_signed_only_R3: assert (opcode == 4'b0100 || opcode == 4'b0110);
    if (opcode[3:2] == 2'b10)
      assert_cmp_upper_clear_R6: assert (result[W-1:1] == '0);
    if (opcode[3:2] == 2'b01)
      assert_zero_matches_R4: assert (zero == (result == '0));
    if (opcode[3:2] == 2'b11 && shamt == '0)
      assert_shift_zero_identity_R8: assert (result == opa);
  end
endmodule

bind alu_classsel alu_classsel_checker #(.W(W), .SHW(SHW)) u_chk (
  .opa(opa), .opb(opb), .shamt(shamt), .opcode(opcode),
  .result(result), .ovf(ovf), .zero(zero)
);

// File: tb/alu_classsel_bench.sv
module alu_classsel_bench;
  localparam int W = 32;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] opa, opb, result;
  logic [4:0]   shamt;
  logic [3:0]   opcode;
  logic         ovf, zero;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  alu_classsel u_alu_classsel (
    .opa(opa), .opb(opb), .shamt(shamt), .opcode(opcode),
    .result(result), .ovf(ovf), .zero(zero)
  );

  // {opcode, A, B, shamt, result, ovf, zero}
  localparam logic [106:0] VEC [NV] = '{
    {4'h0, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0,  32'h00F0_1200, 1'b0, 1'b0},
    {4'h1, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0,  32'hFFF0_FF34, 1'b0, 1'b0},
    {4'h2, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0,  32'hFF00_ED34, 1'b0, 1'b0},
    {4'h3, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0,  32'h000F_00CB, 1'b0, 1'b0},
    {4'h4, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0,  32'h8000_0000, 1'b1, 1'b0},
    {4'h5, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0,  32'h8000_0000, 1'b0, 1'b0},
    {4'h6, 32'h8000_0000, 32'h0000_0001, 5'd0,  32'h7FFF_FFFF, 1'b1, 1'b0},
    {4'h7, 32'h0000_0005, 32'h0000_0005, 5'd0,  32'h0000_0000, 1'b0, 1'b1},
    {4'h4, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0,  32'h0000_0000, 1'b0, 1'b1},
    {4'hA, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0,  32'h0000_0001, 1'b0, 1'b0},
    {4'hB, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0,  32'h0000_0000, 1'b0, 1'b0},
    {4'hA, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0,  32'h0000_0001, 1'b0, 1'b0},
    {4'hA, 32'h0000_0005, 32'h0000_0005, 5'd0,  32'h0000_0000, 1'b0, 1'b1},
    {4'hB, 32'h0000_0003, 32'h0000_0007, 5'd0,  32'h0000_0001, 1'b0, 1'b0},
    {4'h8, 32'h0000_0001, 32'h0000_0002, 5'd0,  32'h0000_0000, 1'b0, 1'b0},
    {4'hC, 32'h8000_0001, 32'h0000_0000, 5'd4,  32'h0000_0010, 1'b0, 1'b0},
    {4'hE, 32'h8000_0001, 32'h0000_0000, 5'd4,  32'h0800_0000, 1'b0, 1'b0},
    {4'hF, 32'h8000_0001, 32'h0000_0000, 5'd4,  32'hF800_0000, 1'b0, 1'b0},
    {4'hD, 32'h1234_5678, 32'h0000_0000, 5'd7,  32'h1234_5678, 1'b0, 1'b0},
    {4'hF, 32'h8000_0000, 32'h0000_0000, 5'd31, 32'hFFFF_FFFF, 1'b0, 1'b0},
    {4'hC, 32'hDEAD_BEEF, 32'h0000_0000, 5'd0,  32'hDEAD_BEEF, 1'b0, 1'b0},
    {4'hE, 32'h8000_0000, 32'h0000_0000, 5'd31, 32'h0000_0001, 1'b0, 1'b0},
    {4'hA, 32'h0000_0003, 32'hFFFF_FFFE, 5'd0,  32'h0000_0000, 1'b0, 1'b0},
    {4'hB, 32'h0000_0000, 32'h0000_0000, 5'd0,  32'h0000_0000, 1'b0, 1'b1}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op[3:2])
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return (op[1:0] == 2'b10) ? "R5" : "R6";
      default: return (op[1:0] == 2'b01) ? "R7 pass" : "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (op=%b A=%h B=%h sh=%0d)",
               req, act, exp, opcode, opa, opb, shamt);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [4:0] s);
    @(negedge clk);
    opcode = op; opa = a; opb = b; shamt = s;
    #1;
  endtask

  initial begin
    opcode = '0; opa = '0; opb = '0; shamt = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("reset R1", result, '0);
    chk("reset R3", {31'b0, ovf}, 32'd0);
    chk("reset R4", {31'b0, zero}, 32'd1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][106:103], VEC[i][102:71], VEC[i][70:39], VEC[i][38:34]);
      chk(tag_of(opcode), result, VEC[i][33:2]);
      chk("R3 ovf", {31'b0, ovf}, {31'b0, VEC[i][1]});
      chk("R4 zero", {31'b0, zero}, {31'b0, VEC[i][0]});
    end

    for (int s = 0; s < W; s++) begin
      apply(4'hC, 32'h0000_0001, 32'h0, 5'(s));
      chk("R8 sll sweep", result, 32'h1 << s);
      apply(4'hF, 32'h8000_0000, 32'h0, 5'(s));
      chk("R8 sra sweep", result, ~(32'h7FFF_FFFF >> s));
    end

    apply(4'h6, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    chk("R3 sub pos-neg", {31'b0, ovf}, 32'd1);
    apply(4'hA, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    chk("R5 max vs min", result, 32'd0);
    apply(4'h9, 32'h0000_0001, 32'h0000_0009, 5'd0);
    chk("R6 code 1001", result, 32'd0);
    apply(4'hB, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 5'd0);
    chk("R6 sltu high", result, 32'd1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule